// File: doc/BRIEF.md
# Interleaved Memory Bank Reply Sequencer

This block stands in for one bank of an interleaved memory on a shared packet bus. Every clock it looks at the cycle on the bus. It claims a request when two things hold: the command is one of the three request kinds, and the address, taken modulo the number of banks, selects this bank. Claimed requests are queued in arrival order. They are served one at a time, and each one occupies the bank for a fixed service time.

The reply must be ready as soon as service ends. To allow for that, the bank asks the arbiter for the bus a set number of cycles early: the service time minus the arbiter's own latency. The request carries a reply header and a packet length. While the grant is outstanding the service count stands still and a wait counter climbs. Queueing of new requests goes on during this wait. A request that arrives when the queue is full is dropped and raises a sticky error flag.

Top module: `bankReplySequencer`

## Requirements
- R1: Synchronous active-high reset empties the queue and clears all state. After reset, arbReq, overflow and grantWaitCnt are all 0.
- R2: The command encoding is 1 = read block, 2 = write block, 3 = write single. A bus cycle is claimed only if busValid is 1, busCmd is 1, 2 or 3, and busAddr modulo BANK_COUNT equals BANK_ID. Every other cycle has no effect on any output.
- R3: Claimed requests are served in arrival order. The queue holds FIFO_DEPTH entries. A claimed request that finds the queue full, with no entry leaving on that edge, is dropped and sets overflow. Overflow stays at 1 until reset.
- R4: When the bank is idle, service of the oldest request starts on the same edge it becomes available. This includes a request claimed on that very edge while the queue is empty.
- R5: arbReq rises exactly SVC_LAT-ARB_LAT service steps after a request's service starts.
- R6: The reply command is the request command with bit 2 set: 5 = read-block reply, 6 = write-block reply, 7 = write-single reply. replyDst is the requester's busSrc, replySrc is BANK_ID, and replyAddr is the request's address. All header fields are updated on the edge where arbReq rises.
- R7: replyBeats is 5 for a read-block reply and 2 for either write reply.
- R8: On each edge where arbReq is 1 and grant is 0, grantWaitCnt increments, while the service count and the header hold. grantWaitCnt returns to 0 when a new arbitration request is posted.
- R9: On an edge where arbReq is 1 and grant is 1, arbReq falls and the service count advances on that same edge.
- R10: When a service reaches SVC_LAT steps, the next queued request starts on that same edge with no idle gap. If nothing is queued, the bank goes idle.
- R11: Elaboration fails unless SVC_LAT is greater than ARB_LAT and ARB_LAT is at least 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busValid | input | 1 | A bus cycle is present |
| busCmd | input | 3 | Bus command code |
| busSrc | input | ID_W | ID of the device that drove the cycle |
| busAddr | input | ADDR_W | Address carried by the cycle |
| grant | input | 1 | The arbiter grants the pending request |
| arbReq | output | 1 | Arbitration request pending |
| replyBeats | output | 3 | Reply packet length in cycles |
| replyCmd | output | 3 | Reply command |
| replyDst | output | ID_W | Reply destination (the requester) |
| replySrc | output | ID_W | Reply source (this bank) |
| replyAddr | output | ADDR_W | Echoed request address |
| grantWaitCnt | output | WAIT_W | Number of cycles the current request has waited for a grant |
| overflow | output | 1 | Sticky flag: a request was dropped |

## Verification
A service counter that drifts by even one step shows at the ports as an arbReq edge in the wrong cycle. This appears within one service time of the fault, and the bench compares arbReq on every cycle. A queue with a broken pointer or count shows up at the next arbitration request, as a header whose address or requester does not match arrival order, or as an overflow flag raised too early or too late. A faulty freeze during a stall shows at once, as grantWaitCnt failing to climb or arbReq moving while grant is low.

// File: rtl/bankSeqPkg.sv
package bankSeqPkg;

  localparam logic [2:0] CMD_RB_REQ  = 3'd1;
  localparam logic [2:0] CMD_WB_REQ  = 3'd2;
  localparam logic [2:0] CMD_WS_REQ  = 3'd3;
  localparam logic [2:0] CMD_RB_RPLY = 3'd5;
  localparam logic [2:0] CMD_WB_RPLY = 3'd6;
  localparam logic [2:0] CMD_WS_RPLY = 3'd7;

  localparam logic [2:0] BEATS_LONG  = 3'd5;
  localparam logic [2:0] BEATS_SHORT = 3'd2;

  // strobes from the sequencing control to the datapath
  typedef struct packed {
    logic takeNext;   // load the queue head as the request in service
    logic postReq;    // latch the reply header for arbitration
  } seqStrobes_t;

  function automatic logic isRequest(input logic [2:0] cmd);
    return (cmd == CMD_RB_REQ) || (cmd == CMD_WB_REQ) || (cmd == CMD_WS_REQ);
  endfunction

  function automatic logic [2:0] replyOf(input logic [2:0] cmd);
    case (cmd)
      CMD_RB_REQ: return CMD_RB_RPLY;
      CMD_WB_REQ: return CMD_WB_RPLY;
      default:    return CMD_WS_RPLY;
    endcase
  endfunction

  function automatic logic [2:0] beatsOf(input logic [2:0] cmd);
    return (cmd == CMD_RB_REQ) ? BEATS_LONG : BEATS_SHORT;
  endfunction

endpackage

// File: rtl/bankReqQueue.sv
module bankReqQueue #(
  parameter int ENTRY_W = 23,
  parameter int DEPTH   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pushValid,
  input  logic [ENTRY_W-1:0] pushData,
  input  logic               popReq,
  output logic               headValid,
  output logic [ENTRY_W-1:0] headData,
  output logic               overflow
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [ENTRY_W-1:0] store [DEPTH];
  logic [PTR_W-1:0]   rdPtr, wrPtr;
  logic [CNT_W-1:0]   count;
  logic               storeEmpty, storeFull;
  logic               fromStore, bypass, doWrite, dropNow;

  assign storeEmpty = (count == '0);
  assign storeFull  = (count == FULL_CNT);

  // the head is the oldest stored entry, or the incoming one when empty
  assign headValid = !storeEmpty || pushValid;
  assign headData  = storeEmpty ? pushData : store[rdPtr];

  assign fromStore = popReq && !storeEmpty;
  assign bypass    = popReq && storeEmpty;
  assign doWrite   = pushValid && !bypass && (!storeFull || fromStore);
  assign dropNow   = pushValid && !bypass && storeFull && !fromStore;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      rdPtr    <= '0;
      wrPtr    <= '0;
      count    <= '0;
      overflow <= 1'b0;
    end else begin
      if (fromStore) rdPtr <= nextPtr(rdPtr);
      if (doWrite)   wrPtr <= nextPtr(wrPtr);
      case ({doWrite, fromStore})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (dropNow) overflow <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (doWrite) store[wrPtr] <= pushData;
  end

endmodule

// File: rtl/bankSeqCtrl.sv
module bankSeqCtrl
  import bankSeqPkg::*;
#(
  parameter int SVC_LAT = 15,
  parameter int ARB_LAT = 3,
  parameter int WAIT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              headValid,
  input  logic              grant,
  output seqStrobes_t       strobes,
  output logic              arbReq,
  output logic [WAIT_W-1:0] grantWaitCnt
);

  localparam int CNT_W = $clog2(SVC_LAT + 1);
  localparam logic [CNT_W-1:0] POST_AT = CNT_W'(SVC_LAT - ARB_LAT);
  localparam logic [CNT_W-1:0] END_AT  = CNT_W'(SVC_LAT);
  localparam logic [CNT_W-1:0] FIRST   = CNT_W'(1);

  logic [CNT_W-1:0]  svcCnt, svcCntNext;
  logic              reqNext;
  logic [WAIT_W-1:0] waitNext;
  logic              stalled;

  assign stalled = arbReq && !grant;

  always_comb begin
    strobes    = '0;
    svcCntNext = svcCnt;
    reqNext    = arbReq;
    waitNext   = grantWaitCnt;
    if (stalled) begin
      waitNext = grantWaitCnt + 1'b1;
    end else begin
      reqNext = 1'b0;
      if (svcCnt == '0) begin
        if (headValid) begin
          strobes.takeNext = 1'b1;
          svcCntNext       = FIRST;
        end
      end else if (svcCnt == POST_AT) begin
        strobes.postReq = 1'b1;
        reqNext         = 1'b1;
        waitNext        = '0;
        svcCntNext      = svcCnt + 1'b1;
      end else if (svcCnt == END_AT) begin
        if (headValid) begin
          strobes.takeNext = 1'b1;
          svcCntNext       = FIRST;
        end else begin
          svcCntNext = '0;
        end
      end else begin
        svcCntNext = svcCnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      svcCnt       <= '0;
      arbReq       <= 1'b0;
      grantWaitCnt <= '0;
    end else begin
      svcCnt       <= svcCntNext;
      arbReq       <= reqNext;
      grantWaitCnt <= waitNext;
    end
  end

endmodule

// File: rtl/bankReplyPath.sv
module bankReplyPath
  import bankSeqPkg::*;
#(
  parameter int BANK_COUNT = 4,
  parameter int BANK_ID    = 0,
  parameter int ID_W       = 4,
  parameter int ADDR_W     = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busValid,
  input  logic [2:0]        busCmd,
  input  logic [ADDR_W-1:0] busAddr,
  input  seqStrobes_t       strobes,
  input  logic [2:0]        headCmd,
  input  logic [ID_W-1:0]   headSrc,
  input  logic [ADDR_W-1:0] headAddr,
  output logic              claimNow,
  output logic [2:0]        replyBeats,
  output logic [2:0]        replyCmd,
  output logic [ID_W-1:0]   replyDst,
  output logic [ID_W-1:0]   replySrc,
  output logic [ADDR_W-1:0] replyAddr
);

  localparam logic [31:0]     BANK_SEL = 32'(BANK_ID);
  localparam logic [31:0]     BANKS    = 32'(BANK_COUNT);
  localparam logic [ID_W-1:0] OWN_ID   = ID_W'(BANK_ID);

  logic [2:0]        curCmd;
  logic [ID_W-1:0]   curSrc;
  logic [ADDR_W-1:0] curAddr;
  logic              bankHit;

  assign bankHit  = ((32'(busAddr) % BANKS) == BANK_SEL);
  assign claimNow = busValid && isRequest(busCmd) && bankHit;

  // request in service
  always_ff @(posedge clk) begin
    if (rst) begin
      curCmd  <= '0;
      curSrc  <= '0;
      curAddr <= '0;
    end else if (strobes.takeNext) begin
      curCmd  <= headCmd;
      curSrc  <= headSrc;
      curAddr <= headAddr;
    end
  end

  // reply header presented with the arbitration request
  always_ff @(posedge clk) begin
    if (rst) begin
      replyCmd   <= '0;
      replyBeats <= '0;
      replyDst   <= '0;
      replySrc   <= '0;
      replyAddr  <= '0;
    end else if (strobes.postReq) begin
      replyCmd   <= replyOf(curCmd);
      replyBeats <= beatsOf(curCmd);
      replyDst   <= curSrc;
      replySrc   <= OWN_ID;
      replyAddr  <= curAddr;
    end
  end

endmodule

// File: rtl/bankReplySequencer.sv
module bankReplySequencer
  import bankSeqPkg::*;
#(
  parameter int BANK_COUNT = 4,
  parameter int BANK_ID    = 0,
  parameter int ID_W       = 4,
  parameter int ADDR_W     = 16,
  parameter int SVC_LAT    = 15,
  parameter int ARB_LAT    = 3,
  parameter int FIFO_DEPTH = 4,
  parameter int WAIT_W     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busValid,
  input  logic [2:0]        busCmd,
  input  logic [ID_W-1:0]   busSrc,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              grant,
  output logic              arbReq,
  output logic [2:0]        replyBeats,
  output logic [2:0]        replyCmd,
  output logic [ID_W-1:0]   replyDst,
  output logic [ID_W-1:0]   replySrc,
  output logic [ADDR_W-1:0] replyAddr,
  output logic [WAIT_W-1:0] grantWaitCnt,
  output logic              overflow
);

  localparam int ENTRY_W = 3 + ID_W + ADDR_W;

  // R11: latency ordering is a hard elaboration constraint
  if (SVC_LAT <= ARB_LAT || ARB_LAT < 1) begin : gBadLatency
    $error("service latency must exceed arbiter latency, which must be at least 1");
  end
  if (ADDR_W > 32 || FIFO_DEPTH < 2 || BANK_ID >= BANK_COUNT) begin : gBadShape
    $error("unsupported address width, queue depth or bank selection");
  end

  seqStrobes_t        strobes;
  logic               claimNow, headValid;
  logic [ENTRY_W-1:0] headData;

  bankReqQueue #(.ENTRY_W(ENTRY_W), .DEPTH(FIFO_DEPTH)) uQueue (
    .clk       (clk),
    .rst       (rst),
    .pushValid (claimNow),
    .pushData  ({busCmd, busSrc, busAddr}),
    .popReq    (strobes.takeNext),
    .headValid (headValid),
    .headData  (headData),
    .overflow  (overflow)
  );

  bankSeqCtrl #(.SVC_LAT(SVC_LAT), .ARB_LAT(ARB_LAT), .WAIT_W(WAIT_W)) uCtrl (
    .clk          (clk),
    .rst          (rst),
    .headValid    (headValid),
    .grant        (grant),
    .strobes      (strobes),
    .arbReq       (arbReq),
    .grantWaitCnt (grantWaitCnt)
  );

  bankReplyPath #(
    .BANK_COUNT(BANK_COUNT), .BANK_ID(BANK_ID), .ID_W(ID_W), .ADDR_W(ADDR_W)
  ) uPath (
    .clk        (clk),
    .rst        (rst),
    .busValid   (busValid),
    .busCmd     (busCmd),
    .busAddr    (busAddr),
    .strobes    (strobes),
    .headCmd    (headData[ENTRY_W-1 -: 3]),
    .headSrc    (headData[ADDR_W +: ID_W]),
    .headAddr   (headData[ADDR_W-1:0]),
    .claimNow   (claimNow),
    .replyBeats (replyBeats),
    .replyCmd   (replyCmd),
    .replyDst   (replyDst),
    .replySrc   (replySrc),
    .replyAddr  (replyAddr)
  );

endmodule

// File: rtl/bankSeqChecker.sv
module bankSeqChecker #(
  parameter int BANK_ID = 0,
  parameter int ID_W    = 4,
  parameter int ADDR_W  = 16,
  parameter int WAIT_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              grant,
  input logic              arbReq,
  input logic [2:0]        replyBeats,
  input logic [2:0]        replyCmd,
  input logic [ID_W-1:0]   replyDst,
  input logic [ID_W-1:0]   replySrc,
  input logic [ADDR_W-1:0] replyAddr,
  input logic [WAIT_W-1:0] grantWaitCnt,
  input logic              overflow
);

  assert_grant_drops_req_R9: assert property (@(posedge clk) disable iff (rst)
    arbReq && grant |=> !arbReq);

  assert_stall_counts_R8: assert property (@(posedge clk) disable iff (rst)
    arbReq && !grant |=> arbReq && (grantWaitCnt == WAIT_W'($past(grantWaitCnt) + 1'b1)));

  assert_stall_header_hold_R8: assert property (@(posedge clk) disable iff (rst)
    arbReq && !grant |=> $stable(replyCmd) && $stable(replyAddr) && $stable(replyDst)
                         && $stable(replyBeats));

  assert_beats_match_R7: assert property (@(posedge clk) disable iff (rst)
    arbReq |-> ((replyCmd == 3'd5) == (replyBeats == 3'd5)));

  assert_reply_source_R6: assert property (@(posedge clk) disable iff (rst)
    arbReq |-> (replySrc == ID_W'(BANK_ID)) && replyCmd[2]);

  assert_overflow_sticky_R3: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);

  assert_wait_cleared_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(arbReq) |-> (grantWaitCnt == '0));

endmodule

bind bankReplySequencer bankSeqChecker #(
  .BANK_ID(BANK_ID), .ID_W(ID_W), .ADDR_W(ADDR_W), .WAIT_W(WAIT_W)
) uChecker (
  .clk(clk), .rst(rst), .grant(grant), .arbReq(arbReq), .replyBeats(replyBeats),
  .replyCmd(replyCmd), .replyDst(replyDst), .replySrc(replySrc), .replyAddr(replyAddr),
  .grantWaitCnt(grantWaitCnt), .overflow(overflow)
);

// File: tb/bankReplySequencer_test.sv
module bankReplySequencer_test;

  localparam int NB    = 4;
  localparam int BID   = 2;
  localparam int IDW   = 4;
  localparam int AW    = 16;
  localparam int SVC   = 15;
  localparam int ARB   = 3;
  localparam int DEPTH = 4;
  localparam int WW    = 8;

  logic clk = 0, rst = 1;
  logic busValid = 0, grant = 0;
  logic [2:0] busCmd = 0;
  logic [IDW-1:0] busSrc = 0;
  logic [AW-1:0] busAddr = 0;
  logic arbReq, overflow;
  logic [2:0] replyBeats, replyCmd;
  logic [IDW-1:0] replyDst, replySrc;
  logic [AW-1:0] replyAddr;
  logic [WW-1:0] grantWaitCnt;

  bankReplySequencer #(.BANK_COUNT(NB), .BANK_ID(BID), .ID_W(IDW), .ADDR_W(AW),
    .SVC_LAT(SVC), .ARB_LAT(ARB), .FIFO_DEPTH(DEPTH), .WAIT_W(WW)) uut (
    .clk(clk), .rst(rst), .busValid(busValid), .busCmd(busCmd), .busSrc(busSrc),
    .busAddr(busAddr), .grant(grant), .arbReq(arbReq), .replyBeats(replyBeats),
    .replyCmd(replyCmd), .replyDst(replyDst), .replySrc(replySrc), .replyAddr(replyAddr),
    .grantWaitCnt(grantWaitCnt), .overflow(overflow));

  always #4 clk = ~clk;

  int checks = 0, failures = 0, cycles = 0;
  bit finished = 0;

  // reference state
  int qCmd[$], qSrc[$], qAddr[$];
  int mCnt, mWait, curC, curS, curA, eCmd, eBeats, eDst, eAddr;
  bit mReq, mOvf;

  function automatic int expReply(input int c);   // R6 mapping
    return c + 4;
  endfunction
  function automatic int expBeats(input int c);   // R7 lengths
    return (c == 1) ? 5 : 2;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  task automatic modelReset();
    qCmd.delete(); qSrc.delete(); qAddr.delete();
    mCnt = 0; mWait = 0; mReq = 0; mOvf = 0;
    curC = 0; curS = 0; curA = 0; eCmd = 0; eBeats = 0; eDst = 0; eAddr = 0;
  endtask

  task automatic modelEdge(input bit v, input int cmd, input int src, input int addr,
                           input bit g);
    bit acc, bypassed;
    acc = v && cmd >= 1 && cmd <= 3 && (addr % NB == BID);   // R2
    bypassed = 0;
    if (mReq && !g) mWait = (mWait + 1) % (1 << WW);          // R8
    else begin
      mReq = 0;                                              // R9
      if (mCnt == 0 || mCnt == SVC) begin                    // R4, R10
        if (qCmd.size() > 0) begin
          curC = qCmd.pop_front(); curS = qSrc.pop_front(); curA = qAddr.pop_front();
          mCnt = 1;
        end else if (acc) begin
          curC = cmd; curS = src; curA = addr; bypassed = 1; mCnt = 1;
        end else mCnt = 0;
      end else if (mCnt == SVC - ARB) begin                  // R5
        mReq = 1; mWait = 0;
        eCmd = expReply(curC); eBeats = expBeats(curC); eDst = curS; eAddr = curA;
        mCnt++;
      end else mCnt++;
    end
    if (acc && !bypassed) begin                              // R3
      if (qCmd.size() < DEPTH) begin
        qCmd.push_back(cmd); qSrc.push_back(src); qAddr.push_back(addr);
      end else mOvf = 1;
    end
  endtask

  task automatic compareAll();
    check("R5/R9 arbReq", arbReq, mReq);
    check("R6 replyCmd", replyCmd, eCmd);
    check("R6 replyDst", replyDst, eDst);
    check("R6 replySrc", replySrc, (eCmd == 0) ? 0 : BID);
    check("R6 replyAddr", replyAddr, eAddr);
    check("R7 replyBeats", replyBeats, eBeats);
    check("R8 grantWaitCnt", grantWaitCnt, mWait);
    check("R3 overflow", overflow, mOvf);
  endtask

  // inputs are applied just after a falling edge and sampled at the rising edge
  task automatic step(input bit v, input int cmd, input int src, input int addr,
                      input bit g);
    busValid = v; busCmd = 3'(cmd); busSrc = IDW'(src); busAddr = AW'(addr); grant = g;
    @(posedge clk);
    cycles++;
    modelEdge(v, cmd, src, addr, g);
    @(negedge clk);
    compareAll();
  endtask

  task automatic doReset();
    rst = 1; busValid = 0; grant = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    modelReset();
    check("R1 arbReq after reset", arbReq, 0);
    check("R1 overflow after reset", overflow, 0);
    check("R1 grantWaitCnt after reset", grantWaitCnt, 0);
  endtask

  function automatic int hitAddr(input int base);
    return (base / NB) * NB + BID;
  endfunction

  initial begin
    for (int w = 0; w < 200000; w++) begin
      @(posedge clk);
      if (finished) break;
    end
    if (!finished) begin
      failures++; checks++;
      $display("FAIL watchdog expired: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20517));
    doReset();

    // R4: one read-block request, bypassed straight into service, immediate grant
    step(1, 1, 9, hitAddr(100), 0);
    for (int i = 0; i < 30; i++) step(0, 0, 0, 0, arbReq);

    // R2: foreign banks and non-request commands never produce a reply
    for (int i = 0; i < 40; i++) step(1, i % 8, 3, hitAddr(40) + 1 + (i % 3), 0);
    for (int i = 0; i < 10; i++) step(1, 0, 5, hitAddr(200), 0);
    for (int i = 4; i < 8; i++) step(1, i, 5, hitAddr(300), 0);
    check("R2 no request from ignored cycles", arbReq, 0);

    // R8: long grant stall with queueing continuing, then release
    step(1, 3, 4, hitAddr(500), 0);
    for (int i = 0; i < 14; i++) step(0, 0, 0, 0, 0);
    for (int i = 0; i < 40; i++) step((i % 9) == 0, 2, i % 16, hitAddr(600 + i * 4), 0);
    step(0, 0, 0, 0, 1);
    for (int i = 0; i < 200; i++) step(0, 0, 0, 0, arbReq);

    // R3 and R10: flood beyond depth, back-to-back service in order
    for (int i = 0; i < 8; i++) step(1, 1 + (i % 3), i, hitAddr(1000 + i * 8), 0);
    check("R3 overflow after flood", overflow, 1);
    for (int i = 0; i < 150; i++) step(0, 0, 0, 0, arbReq);

    // R1: reset mid-run clears the sticky flag
    doReset();

    // random mix
    for (int i = 0; i < 4000; i++) begin
      bit v, g;
      int c, s, a;
      v = ($urandom % 10) == 0;
      c = $urandom % 8;
      s = $urandom % 16;
      a = $urandom % 65536;
      g = ($urandom % 3) == 0;
      step(v, c, s, a, g);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule